// File: doc/BRIEF.md
# Exception Dispatch and Return Unit

This unit sits at the retirement boundary of a processor pipeline and decides where control goes when something exceptional happens. Several detectors inside the core can raise a synchronous exception for the instruction now at the boundary, each with an 8-bit exception number. An external interrupt line, which comes with its own vector number, can also ask for service. At each instruction boundary the unit picks one event and looks up its handler entry point in a 256-entry table that software loads. It then tells the front end to redirect there.

The exception number sets the class, and the class sets the return action. A fault saves the address of the faulting instruction so that it runs again after the handler. A trap or an interrupt saves the address of the next instruction. An abort saves no resume address and raises an abort flag for the current program. A single kernel flag is set by every redirect. It keeps the interrupt line masked until a return-from-exception strobe clears it.

Top module: `exc_dispatch`

## Requirements
- R1: After a synchronous active-low reset, redirect_valid, abort and kernel_mode are 0, target_pc, saved_pc and cause are 0, and every handler table entry reads as 0.
- R2: Asserting tbl_we with tbl_idx = k and tbl_data = D makes D the target_pc of any later redirect whose cause is k.
- R3: Cause numbers below 32 other than 18 (including 0, 13 and 14) are faults. They set saved_pc to cur_pc and leave abort at 0.
- R4: Cause 18 is an abort. It sets abort to 1 and saved_pc to 0, and target_pc still comes from table entry 18.
- R5: Cause numbers 32 to 255 raised by a synchronous source are traps. They set saved_pc to cur_pc + instr_len, wrapping modulo 2^32.
- R6: irq_pin, when taken, redirects with cause = irq_vec, saved_pc = cur_pc + instr_len and abort = 0.
- R7: If any synchronous source is valid at a boundary, the interrupt is not taken in that cycle.
- R8: Among valid synchronous sources, the lowest exception number wins, whatever the source index. Invalid sources are ignored.
- R9: Every redirect sets kernel_mode. While kernel_mode is 1, irq_pin is ignored. eret clears kernel_mode, except in a cycle that also takes a redirect, where kernel_mode stays 1.
- R10: Events are evaluated only in a cycle with boundary = 1. The outputs change at the clock edge that samples the boundary. redirect_valid is high for that one cycle, and with boundary = 0 no redirect happens.
- R11: If a table write and a lookup of the same entry happen in the same cycle, the redirect uses the old contents. The new value applies from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tbl_we | input | 1 | Handler table write enable |
| tbl_idx | input | 8 | Handler table entry to write |
| tbl_data | input | 32 | Handler address to write |
| boundary | input | 1 | An instruction boundary is present this cycle |
| cur_pc | input | 32 | Address of the instruction at the boundary |
| instr_len | input | 4 | Length of that instruction in bytes |
| src_valid | input | 3 | Synchronous exception request, one bit per source |
| src_cause | input | 24 | Exception number of each source, 8 bits per source, source 0 in the low bits |
| irq_pin | input | 1 | External interrupt request |
| irq_vec | input | 8 | Exception number of the external interrupt |
| eret | input | 1 | Return from exception, clears the kernel flag |
| redirect_valid | output | 1 | One-cycle strobe: fetch from target_pc |
| target_pc | output | 32 | Handler entry point |
| saved_pc | output | 32 | Return address (0 for an abort) |
| cause | output | 8 | Exception number that was serviced |
| abort | output | 1 | The current program is aborted |
| kernel_mode | output | 1 | Kernel flag |

## Verification
The hardest situations to reach are collisions inside one cycle. Examples are an interrupt arriving together with a synchronous exception, a return-from-exception strobe in the same cycle as a new redirect, and a table write that hits the entry being looked up. Only directed stimulus that lines these up on one boundary can show which side wins. The interrupt mask is reached by leaving the kernel flag set after one redirect and then raising the interrupt line without a return. A trap at the top of the address space, with the longest instruction, checks the wraparound of the return address.

// File: rtl/exc_pkg.sv
// Package: shared constants and types for the exception dispatch unit.
// Assumes exception numbers are at least 6 bits wide so the class limits fit.
package exc_pkg;
    // Return action class of a serviced event
    typedef enum logic [1:0] {
        CLS_FAULT = 2'd0,
        CLS_TRAP  = 2'd1,
        CLS_ABORT = 2'd2
    } exc_class_e;

    localparam int unsigned ABORT_NUM    = 18;
    localparam int unsigned FIRST_SW_NUM = 32;
endpackage

// File: rtl/exc_vec_table.sv
// Handler address table: DEPTH entries of DATA_W bits held in flops.
// Write port is synchronous. Read port is combinational, so a write
// shows up on the read port only from the cycle after it.
module exc_vec_table #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 32,
    localparam int unsigned DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] entry_q [DEPTH];

    // Clear all entries on reset, load one entry per write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) entry_q[i] <= '0;
        end else if (we) begin
            entry_q[waddr] <= wdata;
        end
    end

    // Lookup of the selected handler
    always_comb rdata = entry_q[raddr];
endmodule

// File: rtl/exc_arbiter.sv
// Synchronous cause arbiter: from NUM_SRC requests it picks the valid one
// with the lowest exception number. Assumes no request ordering by source.
module exc_arbiter #(
    parameter int unsigned NUM_SRC = 3,
    parameter int unsigned CAUSE_W = 8
) (
    input  logic [NUM_SRC-1:0]         src_valid,
    input  logic [NUM_SRC*CAUSE_W-1:0] src_cause,
    output logic                       any_valid,
    output logic [CAUSE_W-1:0]         win_cause
);
    logic [CAUSE_W-1:0] cause_arr [NUM_SRC];

    genvar g;
    generate
        for (g = 0; g < NUM_SRC; g++) begin : g_unpack
            assign cause_arr[g] = src_cause[g*CAUSE_W +: CAUSE_W];
        end
    endgenerate

    // Keep the smallest valid number seen so far
    always_comb begin
        any_valid = 1'b0;
        win_cause = '1;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (src_valid[i] && (!any_valid || cause_arr[i] < win_cause)) begin
                win_cause = cause_arr[i];
                any_valid = 1'b1;
            end
        end
    end
endmodule

// File: rtl/exc_classify.sv
// Class decode and return address: maps the chosen event to fault, trap or
// abort and forms the address to resume at. Assumes instr_len is the byte
// length of the instruction at cur_pc.
module exc_classify
    import exc_pkg::*;
#(
    parameter int unsigned CAUSE_W = 8,
    parameter int unsigned PC_W    = 32,
    parameter int unsigned LEN_W   = 4
) (
    input  logic [CAUSE_W-1:0] cause_num,
    input  logic               is_irq,
    input  logic [PC_W-1:0]    cur_pc,
    input  logic [LEN_W-1:0]   instr_len,
    output exc_class_e         cls,
    output logic [PC_W-1:0]    ret_pc
);
    // Class from the source and the number range
    always_comb begin
        if (is_irq)                                   cls = CLS_TRAP;
        else if (cause_num == CAUSE_W'(ABORT_NUM))    cls = CLS_ABORT;
        else if (cause_num < CAUSE_W'(FIRST_SW_NUM))  cls = CLS_FAULT;
        else                                          cls = CLS_TRAP;
    end

    // Resume address for the class
    always_comb begin
        unique case (cls)
            CLS_FAULT: ret_pc = cur_pc;
            CLS_TRAP:  ret_pc = cur_pc + PC_W'(instr_len);
            default:   ret_pc = '0;
        endcase
    end
endmodule

// File: rtl/exc_dispatch.sv
// Exception dispatch and return unit (top). At an instruction boundary it
// services the lowest-numbered synchronous exception or, if there is none
// and the kernel flag is clear, the external interrupt. Outputs are
// registered and valid in the cycle after the boundary is sampled.
module exc_dispatch
    import exc_pkg::*;
#(
    parameter int unsigned NUM_SRC = 3,
    parameter int unsigned CAUSE_W = 8,
    parameter int unsigned PC_W    = 32,
    parameter int unsigned LEN_W   = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tbl_we,
    input  logic [CAUSE_W-1:0]         tbl_idx,
    input  logic [PC_W-1:0]            tbl_data,
    input  logic                       boundary,
    input  logic [PC_W-1:0]            cur_pc,
    input  logic [LEN_W-1:0]           instr_len,
    input  logic [NUM_SRC-1:0]         src_valid,
    input  logic [NUM_SRC*CAUSE_W-1:0] src_cause,
    input  logic                       irq_pin,
    input  logic [CAUSE_W-1:0]         irq_vec,
    input  logic                       eret,
    output logic                       redirect_valid,
    output logic [PC_W-1:0]            target_pc,
    output logic [PC_W-1:0]            saved_pc,
    output logic [CAUSE_W-1:0]         cause,
    output logic                       abort,
    output logic                       kernel_mode
);
    logic               sync_any;
    logic [CAUSE_W-1:0] sync_cause;
    logic               take_sync, take_irq, take_any;
    logic [CAUSE_W-1:0] sel_cause;
    logic [PC_W-1:0]    handler_pc;
    logic [PC_W-1:0]    ret_pc;
    exc_class_e         sel_cls;

    exc_arbiter #(.NUM_SRC(NUM_SRC), .CAUSE_W(CAUSE_W)) u_arb (
        .src_valid (src_valid),
        .src_cause (src_cause),
        .any_valid (sync_any),
        .win_cause (sync_cause)
    );

    // Event selection: synchronous causes first, interrupt only when unmasked
    always_comb begin
        take_sync = boundary && sync_any;
        take_irq  = boundary && irq_pin && !kernel_mode && !sync_any;
        take_any  = take_sync || take_irq;
        sel_cause = sync_any ? sync_cause : irq_vec;
    end

    exc_vec_table #(.ADDR_W(CAUSE_W), .DATA_W(PC_W)) u_tbl (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (tbl_we),
        .waddr (tbl_idx),
        .wdata (tbl_data),
        .raddr (sel_cause),
        .rdata (handler_pc)
    );

    exc_classify #(.CAUSE_W(CAUSE_W), .PC_W(PC_W), .LEN_W(LEN_W)) u_cls (
        .cause_num (sel_cause),
        .is_irq    (!sync_any),
        .cur_pc    (cur_pc),
        .instr_len (instr_len),
        .cls       (sel_cls),
        .ret_pc    (ret_pc)
    );

    // Register the redirect and its return information
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            redirect_valid <= 1'b0;
            target_pc      <= '0;
            saved_pc       <= '0;
            cause          <= '0;
            abort          <= 1'b0;
        end else begin
            redirect_valid <= take_any;
            abort          <= take_any && (sel_cls == CLS_ABORT);
            if (take_any) begin
                target_pc <= handler_pc;
                saved_pc  <= ret_pc;
                cause     <= sel_cause;
            end
        end
    end

    // Kernel flag: set on entry, cleared by return unless entry wins
    always_ff @(posedge clk) begin
        if (!rst_n)        kernel_mode <= 1'b0;
        else if (take_any) kernel_mode <= 1'b1;
        else if (eret)     kernel_mode <= 1'b0;
    end
endmodule

// File: rtl/exc_dispatch_chk.sv
// Checker for exc_dispatch: temporal properties on its ports, bound below.
// Assumes synchronous active-low reset on rst_n.
module exc_dispatch_chk #(
    parameter int unsigned NUM_SRC = 3,
    parameter int unsigned PC_W    = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               boundary,
    input logic [NUM_SRC-1:0] src_valid,
    input logic               irq_pin,
    input logic               eret,
    input logic               redirect_valid,
    input logic [PC_W-1:0]    saved_pc,
    input logic               abort,
    input logic               kernel_mode
);
    // R4
    abort_with_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort |-> (redirect_valid && saved_pc == '0));

    // R9
    redirect_sets_kernel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |-> kernel_mode);

    // R9
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary && irq_pin && kernel_mode && !(|src_valid)) |=> !redirect_valid);

    // R9
    eret_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eret && !boundary) |=> !kernel_mode);

    // R10
    no_boundary_no_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !boundary |=> !redirect_valid);

    // R7
    sync_always_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary && (|src_valid)) |=> redirect_valid);
endmodule

bind exc_dispatch exc_dispatch_chk #(.NUM_SRC(NUM_SRC), .PC_W(PC_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .boundary       (boundary),
    .src_valid      (src_valid),
    .irq_pin        (irq_pin),
    .eret           (eret),
    .redirect_valid (redirect_valid),
    .saved_pc       (saved_pc),
    .abort          (abort),
    .kernel_mode    (kernel_mode)
);

// File: tb/exc_dispatch_test.sv
`timescale 1ns/1ps
// Directed bench for exc_dispatch: one task per scenario.
module exc_dispatch_test;
    localparam int NS = 3;
    localparam int CW = 8;
    localparam int PW = 32;
    localparam int LW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tbl_we = 1'b0;
    logic [CW-1:0] tbl_idx = '0;
    logic [PW-1:0] tbl_data = '0;
    logic          boundary = 1'b0;
    logic [PW-1:0] cur_pc = '0;
    logic [LW-1:0] instr_len = '0;
    logic [NS-1:0] src_valid = '0;
    logic [NS*CW-1:0] src_cause = '0;
    logic          irq_pin = 1'b0;
    logic [CW-1:0] irq_vec = '0;
    logic          eret = 1'b0;
    logic          redirect_valid;
    logic [PW-1:0] target_pc;
    logic [PW-1:0] saved_pc;
    logic [CW-1:0] cause;
    logic          abort;
    logic          kernel_mode;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    exc_dispatch #(.NUM_SRC(NS), .CAUSE_W(CW), .PC_W(PW), .LEN_W(LW)) uut (
        .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_idx(tbl_idx),
        .tbl_data(tbl_data), .boundary(boundary), .cur_pc(cur_pc),
        .instr_len(instr_len), .src_valid(src_valid), .src_cause(src_cause),
        .irq_pin(irq_pin), .irq_vec(irq_vec), .eret(eret),
        .redirect_valid(redirect_valid), .target_pc(target_pc),
        .saved_pc(saved_pc), .cause(cause), .abort(abort),
        .kernel_mode(kernel_mode)
    );

    function automatic logic [PW-1:0] hv(input int k);
        return 32'hC000_0000 | (32'(k) << 4);
    endfunction

    task automatic chk_eq(input string req, input string what,
                          input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // Present one boundary for one cycle, then withdraw it
    task automatic fire(input logic [NS-1:0] v, input logic [CW-1:0] c0,
                        input logic [CW-1:0] c1, input logic [CW-1:0] c2,
                        input logic irq, input logic [CW-1:0] iv,
                        input logic [PW-1:0] pc, input logic [LW-1:0] len);
        boundary  = 1'b1;
        src_valid = v;
        src_cause = {c2, c1, c0};
        irq_pin   = irq;
        irq_vec   = iv;
        cur_pc    = pc;
        instr_len = len;
        step();
        boundary  = 1'b0;
        src_valid = '0;
        irq_pin   = 1'b0;
    endtask

    task automatic expect_redirect(input string req, input int c,
                                   input logic [PW-1:0] tgt,
                                   input logic [PW-1:0] sv, input logic ab);
        chk_eq(req, "redirect_valid", 64'(redirect_valid), 64'd1);
        chk_eq(req, "cause", 64'(cause), 64'(c));
        chk_eq(req, "target_pc", 64'(target_pc), 64'(tgt));
        chk_eq(req, "saved_pc", 64'(saved_pc), 64'(sv));
        chk_eq(req, "abort", 64'(abort), 64'(ab));
    endtask

    task automatic do_eret();
        eret = 1'b1;
        step();
        eret = 1'b0;
        chk_eq("R9", "kernel after eret", 64'(kernel_mode), 64'd0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;
        chk_eq("R1", "redirect_valid", 64'(redirect_valid), 64'd0);
        chk_eq("R1", "abort", 64'(abort), 64'd0);
        chk_eq("R1", "kernel_mode", 64'(kernel_mode), 64'd0);
        chk_eq("R1", "target_pc", 64'(target_pc), 64'd0);
        chk_eq("R1", "saved_pc", 64'(saved_pc), 64'd0);
        chk_eq("R1", "cause", 64'(cause), 64'd0);
        // table empty after reset: cause 5 handler reads as zero
        fire(3'b001, 8'd5, 8'd0, 8'd0, 1'b0, 8'd0, 32'h0000_0100, 4'd2);
        expect_redirect("R1", 5, 32'h0, 32'h0000_0100, 1'b0);
        do_eret();
    endtask

    task automatic t_load_table();
        for (int k = 0; k < 256; k++) begin
            tbl_we = 1'b1; tbl_idx = 8'(k); tbl_data = hv(k);
            step();
        end
        tbl_we = 1'b0;
        fire(3'b001, 8'd7, 8'd0, 8'd0, 1'b0, 8'd0, 32'h0000_0200, 4'd1);
        expect_redirect("R2", 7, hv(7), 32'h0000_0200, 1'b0);
        do_eret();
    endtask

    task automatic t_faults();
        fire(3'b001, 8'd14, 8'd0, 8'd0, 1'b0, 8'd0, 32'h0000_1000, 4'd2);
        expect_redirect("R3", 14, hv(14), 32'h0000_1000, 1'b0);
        chk_eq("R9", "kernel set", 64'(kernel_mode), 64'd1);
        step();
        chk_eq("R10", "strobe one cycle", 64'(redirect_valid), 64'd0);
        do_eret();
        fire(3'b010, 8'd0, 8'd0, 8'd0, 1'b0, 8'd0, 32'h0000_1104, 4'd3);
        expect_redirect("R3", 0, hv(0), 32'h0000_1104, 1'b0);
        do_eret();
        fire(3'b100, 8'd0, 8'd0, 8'd13, 1'b0, 8'd0, 32'h0000_1208, 4'd6);
        expect_redirect("R3", 13, hv(13), 32'h0000_1208, 1'b0);
        do_eret();
    endtask

    task automatic t_abort();
        fire(3'b001, 8'd18, 8'd0, 8'd0, 1'b0, 8'd0, 32'h0000_1500, 4'd4);
        expect_redirect("R4", 18, hv(18), 32'h0, 1'b1);
        step();
        chk_eq("R4", "abort drops", 64'(abort), 64'd0);
        do_eret();
    endtask

    task automatic t_traps();
        fire(3'b001, 8'd40, 8'd0, 8'd0, 1'b0, 8'd0, 32'h0000_2000, 4'd5);
        expect_redirect("R5", 40, hv(40), 32'h0000_2005, 1'b0);
        do_eret();
        fire(3'b100, 8'd0, 8'd0, 8'd255, 1'b0, 8'd0, 32'hFFFF_FFF8, 4'd15);
        expect_redirect("R5", 255, hv(255), 32'h0000_0007, 1'b0);
        do_eret();
    endtask

    task automatic t_irq();
        fire(3'b000, 8'd0, 8'd0, 8'd0, 1'b1, 8'd200, 32'h0000_3000, 4'd3);
        expect_redirect("R6", 200, hv(200), 32'h0000_3003, 1'b0);
        // still in kernel: interrupt ignored
        fire(3'b000, 8'd0, 8'd0, 8'd0, 1'b1, 8'd33, 32'h0000_3100, 4'd2);
        chk_eq("R9", "masked irq", 64'(redirect_valid), 64'd0);
        do_eret();
        fire(3'b000, 8'd0, 8'd0, 8'd0, 1'b1, 8'd33, 32'h0000_3100, 4'd2);
        expect_redirect("R6", 33, hv(33), 32'h0000_3102, 1'b0);
        do_eret();
    endtask

    task automatic t_priority();
        fire(3'b001, 8'd40, 8'd0, 8'd0, 1'b1, 8'd200, 32'h0000_4000, 4'd2);
        expect_redirect("R7", 40, hv(40), 32'h0000_4002, 1'b0);
        do_eret();
        fire(3'b111, 8'd40, 8'd200, 8'd13, 1'b0, 8'd0, 32'h0000_4100, 4'd2);
        expect_redirect("R8", 13, hv(13), 32'h0000_4100, 1'b0);
        do_eret();
        fire(3'b011, 8'd18, 8'd0, 8'd3, 1'b0, 8'd0, 32'h0000_4200, 4'd2);
        expect_redirect("R8", 0, hv(0), 32'h0000_4200, 1'b0);
        do_eret();
    endtask

    task automatic t_eret_collide();
        eret = 1'b1;
        fire(3'b001, 8'd40, 8'd0, 8'd0, 1'b0, 8'd0, 32'h0000_5000, 4'd1);
        eret = 1'b0;
        expect_redirect("R9", 40, hv(40), 32'h0000_5001, 1'b0);
        chk_eq("R9", "kernel held on collision", 64'(kernel_mode), 64'd1);
        do_eret();
    endtask

    task automatic t_no_boundary();
        src_valid = 3'b001; src_cause = {8'd0, 8'd0, 8'd14};
        irq_pin = 1'b1; irq_vec = 8'd50;
        step();
        src_valid = '0; irq_pin = 1'b0;
        chk_eq("R10", "no redirect w/o boundary", 64'(redirect_valid), 64'd0);
        chk_eq("R10", "kernel untouched", 64'(kernel_mode), 64'd0);
    endtask

    task automatic t_write_collide();
        tbl_we = 1'b1; tbl_idx = 8'd40; tbl_data = 32'h1234_5670;
        fire(3'b001, 8'd40, 8'd0, 8'd0, 1'b0, 8'd0, 32'h0000_6000, 4'd2);
        tbl_we = 1'b0;
        expect_redirect("R11", 40, hv(40), 32'h0000_6002, 1'b0);
        do_eret();
        fire(3'b001, 8'd40, 8'd0, 8'd0, 1'b0, 8'd0, 32'h0000_6000, 4'd2);
        expect_redirect("R11", 40, 32'h1234_5670, 32'h0000_6002, 1'b0);
        do_eret();
    endtask

    initial begin
        t_reset();
        t_load_table();
        t_faults();
        t_abort();
        t_traps();
        t_irq();
        t_priority();
        t_eret_collide();
        t_no_boundary();
        t_write_collide();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #500000;
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule